// File: doc/BRIEF.md
# Three-Channel Square Tone Generator and Mixer

This block produces three square waves, one for each channel, from periods that software writes as a byte-wide fine part and a 4-bit coarse part. A shared clock-enable tick paces every period counter. When a counter has seen as many ticks as its period, the channel's square output inverts. The tone frequency is therefore the tick rate divided by twice the 12-bit period.

Each channel is then gated by its own square wave and by a shared external noise bit. A mixer register holds active-low disable bits that let either source through unconditionally. A channel whose gate is open drives a 4-bit level. That level is either the channel's fixed volume or, when the channel's mode bit is set, an external envelope level.

All held registers can be read back on a separate combinational read port. The noise generator, the envelope shape generator and the DAC sit outside this block.

Top module: `tone_mixer3`

## Requirements
- R1: While `rst_n` is low, every register, counter and square output is cleared, so every level output reads 0 and every read address returns 0x00.
- R2: Writes take effect on the rising clock edge with `wr_en` high. Fine periods are at 0x0/0x2/0x4 (8 bits) and coarse periods at 0x1/0x3/0x5 (data bits 3:0), for channels A/B/C. The mixer is at 0x7. Levels are at 0x8/0x9/0xA (bits 3:0 volume, bit 4 mode).
- R3: `rd_data` shows the stored value of the register at `rd_addr`. Unstored bits read 0 (coarse bits 7:4, mixer bits 7:6, level bits 7:5). Addresses 0x6 and 0xB–0xF read 0x00.
- R4: With period P = coarse×256 + fine, a channel's square output starts low after reset and, after k ticks, equals bit 0 of k/P (integer division). Clock edges without `tick` do not change it.
- R5: A programmed period of 0 behaves exactly like a period of 1, so the square output inverts on every tick.
- R6: Mixer bits 0/1/2 are active-low tone enables for A/B/C, and bits 3/4/5 are active-low noise enables for A/B/C. A channel's gate is (square OR tone bit) AND (`noise_in` OR noise bit). A closed gate forces that channel's level output to 0.
- R7: With its gate open, a channel outputs its 4-bit volume when its mode bit is 0. When the mode bit is 1, it outputs `env_lvl`, following `env_lvl` as it changes.
- R8: Channels are independent: each uses only its own period, mixer bits and level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the period counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Readback data for `rd_addr` |
| noise_in | input | 1 | Shared noise bit |
| env_lvl | input | 4 | External envelope level |
| lvl_a | output | 4 | Channel A level |
| lvl_b | output | 4 | Channel B level |
| lvl_c | output | 4 | Channel C level |

## Verification
The bench counts ticks against periods of 0, 1, 3 and 256. An off-by-one in the terminal count would show as the square wave inverting one tick early or late. A design that takes 0 literally would stall, or wrap through 4096 ticks, instead of inverting on every tick. Readback of all-ones writes checks for unstored bits leaking into `rd_data`. The bench also walks the four combinations of the mixer's disable bits against `noise_in`, to expose a swapped or inverted enable polarity. Envelope mode is tested while `env_lvl` changes, which catches a level that was latched instead of selected.

// File: rtl/tone_mixer3.sv
module tone_mixer3 #(
  parameter int NCH      = 3,
  parameter int COARSE_W = 4,
  parameter int VOL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             noise_in,
  input  logic [VOL_W-1:0] env_lvl,
  output logic [VOL_W-1:0] lvl_a,
  output logic [VOL_W-1:0] lvl_b,
  output logic [VOL_W-1:0] lvl_c
);
  localparam int PER_W = 8 + COARSE_W;
  localparam int LVL_W = VOL_W + 1;

  logic [NCH-1:0][7:0]          fine_q;
  logic [NCH-1:0][COARSE_W-1:0] coarse_q;
  logic [NCH-1:0][LVL_W-1:0]    lvl_q;
  logic [2*NCH-1:0]             mix_q;
  logic [NCH-1:0][PER_W-1:0]    cnt_q;
  logic [NCH-1:0][PER_W-1:0]    per;
  logic [NCH-1:0]               tone_q;
  logic [NCH-1:0]               gate;
  logic [NCH-1:0][VOL_W-1:0]    lvl_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q   <= '0;
      coarse_q <= '0;
      lvl_q    <= '0;
      mix_q    <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == 4'(2*i))     fine_q[i]   <= wr_data;
        if (wr_addr == 4'(2*i + 1)) coarse_q[i] <= wr_data[COARSE_W-1:0];
        if (wr_addr == 4'(8 + i))   lvl_q[i]    <= wr_data[LVL_W-1:0];
      end
      if (wr_addr == 4'h7) mix_q <= wr_data[2*NCH-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      per[i] = {coarse_q[i], fine_q[i]};
      if (per[i] == '0) per[i] = PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= '0;
    end else if (tick) begin
      for (int i = 0; i < NCH; i++) begin
        if (cnt_q[i] >= per[i] - PER_W'(1)) begin
          cnt_q[i]  <= '0;
          tone_q[i] <= ~tone_q[i];
        end else begin
          cnt_q[i] <= cnt_q[i] + PER_W'(1);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      gate[i]  = (tone_q[i] | mix_q[i]) & (noise_in | mix_q[NCH+i]);
      lvl_o[i] = !gate[i] ? '0 : (lvl_q[i][VOL_W] ? env_lvl : lvl_q[i][VOL_W-1:0]);
    end
  end

  assign lvl_a = lvl_o[0];
  assign lvl_b = lvl_o[1];
  assign lvl_c = lvl_o[2];

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == 4'(2*i))     rd_data = fine_q[i];
      if (rd_addr == 4'(2*i + 1)) rd_data = 8'(coarse_q[i]);
      if (rd_addr == 4'(8 + i))   rd_data = 8'(lvl_q[i]);
    end
    if (rd_addr == 4'h7) rd_data = 8'(mix_q);
  end
endmodule

module tone_mixer3_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [2:0] tone,
  input logic [7:0] fine_a,
  input logic [3:0] env_lvl,
  input logic [3:0] lvl_a,
  input logic [4:0] lvl_reg_a
);
  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone));
  a_r4_change_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone) |-> $past(tick));
  a_r2_fine_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h0) |=> fine_a == $past(wr_data));
  a_r7_level_source: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_a != 4'h0 |-> (lvl_a == env_lvl || lvl_a == lvl_reg_a[3:0]));
  a_r7_env_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_reg_a[4] && lvl_a != 4'h0) |-> lvl_a == env_lvl);
endmodule

bind tone_mixer3 tone_mixer3_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tone(tone_q), .fine_a(fine_q[0]), .env_lvl(env_lvl),
  .lvl_a(lvl_a), .lvl_reg_a(lvl_q[0])
);

// File: tb/tone_mixer3_tb.sv
module tone_mixer3_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, noise_in = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0, env_lvl = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] lvl_a, lvl_b, lvl_c;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tone_mixer3 dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .noise_in(noise_in), .env_lvl(env_lvl), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; wr_en = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset readback", d, 0);
    end
    chk("R1 reset lvl_a", lvl_a, 0);
    chk("R1 reset lvl_b", lvl_b, 0);
    chk("R1 reset lvl_c", lvl_c, 0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 0; a < 16; a++) begin
      int exp;
      rd(4'(a), d);
      case (a)
        0, 2, 4: exp = 8'hFF;
        1, 3, 5: exp = 8'h0F;
        7:       exp = 8'h3F;
        8, 9, 10: exp = 8'h1F;
        default: exp = 0;
      endcase
      chk("R3 readback masks", d, exp);
    end
    wr(4'h2, 8'h5A); rd(4'h2, d); chk("R2 fine B write", d, 8'h5A);
    rd(4'h0, d); chk("R8 fine A untouched", d, 8'hFF);
  endtask

  task automatic t_volume_env();
    do_reset();
    wr(4'h7, 8'h3F);
    wr(4'h8, 8'h07); wr(4'h9, 8'h0C); wr(4'hA, 8'h10);
    env_lvl = 4'h3; #1;
    chk("R7 vol A", lvl_a, 7);
    chk("R7 vol B", lvl_b, 12);
    chk("R7 env C", lvl_c, 3);
    env_lvl = 4'hE; #1;
    chk("R7 env C follows", lvl_c, 14);
    chk("R7 vol A ignores env", lvl_a, 7);
  endtask

  task automatic t_period(input logic [7:0] fine, input logic [7:0] coarse,
                          input int p, input int n);
    do_reset();
    wr(4'h0, fine); wr(4'h1, coarse);
    wr(4'h7, 8'h3E);
    wr(4'h8, 8'h09);
    #1; chk("R4 start low", lvl_a, 0);
    for (int k = 1; k <= n; k++) begin
      ticks(1);
      chk(p == 1 ? "R5 period tone" : "R4 period tone", lvl_a, ((k / p) % 2) ? 9 : 0);
    end
    repeat (5) @(negedge clk);
    #1; chk("R4 no tick hold", lvl_a, ((n / p) % 2) ? 9 : 0);
  endtask

  task automatic t_long_period();
    do_reset();
    wr(4'h0, 8'h00); wr(4'h1, 8'h01);
    wr(4'h7, 8'h3E); wr(4'h8, 8'h04);
    ticks(255); chk("R4 256 before", lvl_a, 0);
    ticks(1);   chk("R4 256 edge", lvl_a, 4);
    ticks(255); chk("R4 256 high", lvl_a, 4);
    ticks(1);   chk("R4 256 back", lvl_a, 0);
  endtask

  task automatic t_gate();
    do_reset();
    wr(4'h8, 8'h0B);
    wr(4'h7, 8'h37);
    noise_in = 0; #1; chk("R6 noise low gates", lvl_a, 0);
    noise_in = 1; #1; chk("R6 noise high passes", lvl_a, 11);
    wr(4'h7, 8'h3F);
    noise_in = 0; #1; chk("R6 all disabled open", lvl_a, 11);
    wr(4'h7, 8'h3E);
    #1; chk("R6 tone low gates", lvl_a, 0);
    ticks(1);
    chk("R6 tone high passes", lvl_a, 11);
    wr(4'h7, 8'h36);
    noise_in = 0; #1; chk("R6 tone and noise: noise low", lvl_a, 0);
    noise_in = 1; #1; chk("R6 tone and noise both high", lvl_a, 11);
  endtask

  task automatic t_indep();
    do_reset();
    wr(4'h2, 8'h02); wr(4'h4, 8'h03);
    wr(4'h7, 8'h3C);
    wr(4'h8, 8'h01); wr(4'h9, 8'h02); wr(4'hA, 8'h03);
    for (int k = 1; k <= 12; k++) begin
      ticks(1);
      chk("R8 chan A period0 as 1", lvl_a, (k % 2) ? 1 : 0);
      chk("R8 chan B", lvl_b, ((k / 2) % 2) ? 2 : 0);
      chk("R8 chan C mixer off", lvl_c, 3);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_volume_env();
    t_period(8'h03, 8'h00, 3, 10);
    t_period(8'h00, 8'h00, 1, 6);
    t_period(8'h01, 8'hF0, 1, 4);
    t_long_period();
    t_gate();
    t_indep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule